// File: doc/BRIEF.md
# Programmable Autopoll Scheduler

This block issues periodic poll requests toward an attached device bus while autopolling is switched on. A command dispatcher sets the on/off state and the poll interval, counted in pulses of a one-millisecond tick. When the interval runs out, the block sends a single-cycle poll strobe to the device side. If the device answers with data, the block wraps those bytes in an unsolicited packet with a fixed two-byte header and holds it until the transfer engine takes it.

Only one poll or packet is in flight at a time. An interval that runs out while the block is still waiting for a reply, or while a packet has not been taken, produces no poll. The interval still reloads, so the poll rhythm stays the same.

Top module: `autopoll_sched`

## Requirements
- R1: After reset, autopolling is off, the interval is 20 ticks, `poll_req_o` is low and `pkt_valid_o` is low.
- R2: An enable write of 1 while off starts a full interval. The first poll strobe comes in the cycle after the interval-th accepted tick that follows the write.
- R3: While enabled, each poll is followed by the next one exactly one interval of ticks later.
- R4: An enable write that carries the current on/off value leaves the countdown unchanged.
- R5: An enable write of 0 while on cancels the pending poll. No poll strobe appears while disabled, whatever ticks arrive.
- R6: A rate write while enabled restarts the countdown with the new value. A rate write while disabled only stores the value, which the next enable uses.
- R7: A reply of N bytes (1 to MAX_BYTES) produces a packet of length N+2. Byte 0 (bits 7:0) is 0x00, byte 1 is 0x40, and reply byte j goes to packet byte j+2. Unused packet bytes read zero. The packet stays valid and stable until `pkt_ready_i` is high.
- R8: A reply of zero bytes produces no packet.
- R9: While a reply is awaited or a packet is untaken, an expiring interval yields no poll strobe but still reloads the countdown.
- R10: A rate write or an enable write of 0 in the same cycle as the tick that would expire the countdown takes priority, and that tick produces no poll.
- R11: `poll_req_o` is high for exactly one cycle per poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_wr_i | input | 1 | Enable write strobe |
| en_val_i | input | 1 | Enable value written |
| rate_wr_i | input | 1 | Rate write strobe |
| rate_val_i | input | RATE_W (8) | Interval in ticks, never zero |
| ms_tick_i | input | 1 | Millisecond tick pulse |
| poll_req_o | output | 1 | Poll strobe to the device side |
| poll_rsp_i | input | 1 | Device reply valid |
| poll_len_i | input | 4 | Reply byte count |
| poll_data_i | input | 8*MAX_BYTES (64) | Reply bytes, byte j at bits 8j+7:8j |
| pkt_valid_o | output | 1 | Packet available |
| pkt_ready_i | input | 1 | Transfer engine takes the packet |
| pkt_len_o | output | 4 | Packet length in bytes |
| pkt_data_o | output | 8*(MAX_BYTES+2) (80) | Packet bytes, byte i at bits 8i+7:8i |

## Verification
Two functions can land in the same cycle: the countdown expiring on a tick, and a dispatcher write (new rate or disable) that restarts or cancels it. The bench steps the tick until one count remains. It then raises the tick together with the write and checks that no strobe follows and that the next poll comes one full new interval later. A second clash, an expiry while a packet is still unaccepted, is judged by the cycle-by-cycle reference model through the strobe count.

// File: rtl/autopoll_pkg.sv
package autopoll_pkg;
   localparam logic [7:0] HDR_KIND   = 8'h00;
   localparam logic [7:0] HDR_POLLED = 8'h40;
   localparam int         HDR_BYTES  = 2;
endpackage

// File: rtl/ap_period_timer.sv
module ap_period_timer #(
   parameter int RATE_W   = 8,
   parameter int DEF_RATE = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_wr_i,
   input  logic              en_val_i,
   input  logic              rate_wr_i,
   input  logic [RATE_W-1:0] rate_val_i,
   input  logic              tick_i,
   output logic              expire_o
);
   localparam logic [RATE_W-1:0] ONE = RATE_W'(1);

   logic              en_q, en_next, turn_on, restart;
   logic [RATE_W-1:0] per_q, next_per, cnt_q;

   always_comb begin
      en_next  = en_wr_i ? en_val_i : en_q;
      turn_on  = en_wr_i & en_val_i & ~en_q;
      restart  = en_next & (turn_on | rate_wr_i);
      next_per = rate_wr_i ? rate_val_i : per_q;
      expire_o = en_q & en_next & ~restart & tick_i & (cnt_q == ONE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         per_q <= RATE_W'(DEF_RATE);
         cnt_q <= '0;
      end else begin
         en_q  <= en_next;
         per_q <= next_per;
         if (!en_next)
            cnt_q <= '0;
         else if (restart)
            cnt_q <= next_per;
         else if (tick_i)
            cnt_q <= (cnt_q == ONE) ? per_q : cnt_q - ONE;
      end
   end

   // dispatcher contract: zero rate never written
   rate_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rate_wr_i |-> rate_val_i != '0);
   // R5
   armed_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |-> cnt_q != '0);
   // R6
   rate_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_wr_i && en_next) |=> cnt_q == $past(rate_val_i));
endmodule

// File: rtl/ap_poll_ctrl.sv
module ap_poll_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic expire_i,
   input  logic pkt_busy_i,
   input  logic rsp_i,
   output logic poll_req_o,
   output logic rsp_take_o,
   output logic wait_o
);
   logic req_q, wait_q, launch;

   always_comb begin
      launch     = expire_i & ~pkt_busy_i & ~wait_q;
      rsp_take_o = wait_q & rsp_i;
      poll_req_o = req_q;
      wait_o     = wait_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         wait_q <= 1'b0;
      end else begin
         req_q <= launch;
         if (launch)
            wait_q <= 1'b1;
         else if (rsp_take_o)
            wait_q <= 1'b0;
      end
   end

   // R11
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      poll_req_o |=> !poll_req_o);
   // R9
   busy_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_busy_i |=> !poll_req_o);
endmodule

// File: rtl/ap_pkt_builder.sv
module ap_pkt_builder
   import autopoll_pkg::*;
#(
   parameter int MAX_BYTES = 8,
   parameter int LEN_W     = 4,
   parameter int PLEN_W    = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          take_i,
   input  logic [LEN_W-1:0]              len_i,
   input  logic [8*MAX_BYTES-1:0]        data_i,
   input  logic                          ready_i,
   output logic                          valid_o,
   output logic [PLEN_W-1:0]             len_o,
   output logic [8*(MAX_BYTES+HDR_BYTES)-1:0] data_o
);
   logic load;
   assign load = take_i & (len_i != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         len_o   <= '0;
         data_o[8*HDR_BYTES-1:0] <= '0;
      end else if (load) begin
         valid_o <= 1'b1;
         len_o   <= PLEN_W'(len_i) + PLEN_W'(HDR_BYTES);
         data_o[7:0]  <= HDR_KIND;
         data_o[15:8] <= HDR_POLLED;
      end else if (valid_o && ready_i) begin
         valid_o <= 1'b0;
      end
   end

   for (genvar j = 0; j < MAX_BYTES; j++) begin : g_byte
      always_ff @(posedge clk) begin
         if (!rst_n)
            data_o[8*(j+HDR_BYTES) +: 8] <= '0;
         else if (load)
            data_o[8*(j+HDR_BYTES) +: 8] <= (j < int'(len_i)) ? data_i[8*j +: 8] : 8'h00;
      end
   end

   // device contract: reply fits the buffer
   len_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |-> int'(len_i) <= MAX_BYTES);
   // R7
   pkt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i) |=> valid_o && $stable(len_o) && $stable(data_o));
   // R8
   empty_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && len_i == '0 && !valid_o) |=> !valid_o);
endmodule

// File: rtl/autopoll_sched.sv
module autopoll_sched
   import autopoll_pkg::*;
#(
   parameter int RATE_W    = 8,
   parameter int DEF_RATE  = 20,
   parameter int MAX_BYTES = 8,
   localparam int LEN_W    = $clog2(MAX_BYTES + 1),
   localparam int PLEN_W   = $clog2(MAX_BYTES + HDR_BYTES + 1)
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   en_wr_i,
   input  logic                                   en_val_i,
   input  logic                                   rate_wr_i,
   input  logic [RATE_W-1:0]                      rate_val_i,
   input  logic                                   ms_tick_i,
   output logic                                   poll_req_o,
   input  logic                                   poll_rsp_i,
   input  logic [LEN_W-1:0]                       poll_len_i,
   input  logic [8*MAX_BYTES-1:0]                 poll_data_i,
   output logic                                   pkt_valid_o,
   input  logic                                   pkt_ready_i,
   output logic [PLEN_W-1:0]                      pkt_len_o,
   output logic [8*(MAX_BYTES+HDR_BYTES)-1:0]     pkt_data_o
);
   if (RATE_W < 2 || RATE_W > 16) begin : g_bad_rate_w
      $error("RATE_W out of range");
   end
   if (DEF_RATE < 1 || DEF_RATE >= (1 << RATE_W)) begin : g_bad_def
      $error("DEF_RATE must be nonzero and fit RATE_W");
   end
   if (MAX_BYTES < 1 || MAX_BYTES > 64) begin : g_bad_max
      $error("MAX_BYTES out of range");
   end

   logic expire, rsp_take, waiting, busy;

   assign busy = pkt_valid_o;

   ap_period_timer #(.RATE_W(RATE_W), .DEF_RATE(DEF_RATE)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .en_wr_i(en_wr_i), .en_val_i(en_val_i),
      .rate_wr_i(rate_wr_i), .rate_val_i(rate_val_i),
      .tick_i(ms_tick_i), .expire_o(expire)
   );

   ap_poll_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .expire_i(expire), .pkt_busy_i(busy), .rsp_i(poll_rsp_i),
      .poll_req_o(poll_req_o), .rsp_take_o(rsp_take), .wait_o(waiting)
   );

   ap_pkt_builder #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .PLEN_W(PLEN_W)) u_pkt (
      .clk(clk), .rst_n(rst_n),
      .take_i(rsp_take), .len_i(poll_len_i), .data_i(poll_data_i),
      .ready_i(pkt_ready_i),
      .valid_o(pkt_valid_o), .len_o(pkt_len_o), .data_o(pkt_data_o)
   );

   // R9
   one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      waiting |-> !pkt_valid_o);
endmodule

// File: tb/autopoll_sched_tb.sv
`timescale 1ns/1ps
module autopoll_sched_tb;
   localparam int MAXB = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en_wr = 1'b0, en_val = 1'b0;
   logic        rate_wr = 1'b0;
   logic [7:0]  rate_val = 8'd0;
   logic        tick = 1'b0;
   logic        poll_req;
   logic        rsp = 1'b0;
   logic [3:0]  rsp_len = 4'd0;
   logic [63:0] rsp_data = '0;
   logic        pkt_valid;
   logic        pkt_ready = 1'b0;
   logic [3:0]  pkt_len;
   logic [79:0] pkt_data;

   int errors = 0, checks = 0, req_count = 0;
   int rsp_n = 0, rsp_delay = 0, seed = 1;
   bit done = 0;
   string tag = "R1";

   // reference model state
   int m_en, m_per, m_cnt, m_wait, m_pv, m_req, m_plen;
   logic [79:0] m_pdata;

   always #2.5 clk = ~clk;

   autopoll_sched u_dut (
      .clk(clk), .rst_n(rst_n),
      .en_wr_i(en_wr), .en_val_i(en_val),
      .rate_wr_i(rate_wr), .rate_val_i(rate_val),
      .ms_tick_i(tick),
      .poll_req_o(poll_req),
      .poll_rsp_i(rsp), .poll_len_i(rsp_len), .poll_data_i(rsp_data),
      .pkt_valid_o(pkt_valid), .pkt_ready_i(pkt_ready),
      .pkt_len_o(pkt_len), .pkt_data_o(pkt_data)
   );

   always @(posedge clk) begin
      int en_next, restart, newper, req_next;
      if (!rst_n) begin
         m_en = 0; m_per = 20; m_cnt = 0; m_wait = 0; m_pv = 0; m_req = 0;
         m_plen = 0; m_pdata = '0;
      end else begin
         en_next  = en_wr ? int'(en_val) : m_en;
         restart  = en_next && ((en_wr && en_val && !m_en) || rate_wr);
         newper   = rate_wr ? int'(rate_val) : m_per;
         req_next = 0;
         if (!en_next) m_cnt = 0;
         else if (restart) m_cnt = newper;
         else if (tick) begin
            if (m_cnt == 1) begin
               if (!m_wait && !m_pv) req_next = 1;
               m_cnt = m_per;
            end else m_cnt = m_cnt - 1;
         end
         if (m_pv && pkt_ready) m_pv = 0;
         if (m_wait && rsp) begin
            m_wait = 0;
            if (rsp_len != 0) begin
               m_pv = 1;
               m_plen = int'(rsp_len) + 2;
               m_pdata = '0;
               m_pdata[15:8] = 8'h40;
               for (int j = 0; j < int'(rsp_len); j++)
                  m_pdata[8*(j+2) +: 8] = rsp_data[8*j +: 8];
            end
         end
         if (req_next) m_wait = 1;
         m_per = newper;
         m_en  = en_next;
         m_req = req_next;
      end
   end

   task automatic check(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (poll_req) req_count++;
         check(poll_req == m_req[0], "poll strobe", poll_req, m_req);
         check(pkt_valid == m_pv[0], "packet valid", pkt_valid, m_pv);
         if (m_pv != 0) begin
            check(int'(pkt_len) == m_plen, "packet length", pkt_len, m_plen);
            checks++;
            if (pkt_data !== m_pdata) begin
               errors++;
               $display("FAIL %s packet bytes: actual=%h expected=%h", tag, pkt_data, m_pdata);
            end
         end
      end
   end

   // device side responder
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && poll_req) begin
            repeat (rsp_delay) @(negedge clk);
            rsp <= 1'b1;
            rsp_len <= 4'(rsp_n);
            for (int j = 0; j < MAXB; j++) rsp_data[8*j +: 8] <= 8'(seed * 7 + j * 13);
            seed++;
            @(negedge clk);
            rsp <= 1'b0;
            rsp_data <= '0;
         end
      end
   end

   task automatic tick_n(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick <= 1'b1;
         @(negedge clk); tick <= 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic en_write(input bit v);
      @(negedge clk); en_wr <= 1'b1; en_val <= v;
      @(negedge clk); en_wr <= 1'b0;
   endtask

   task automatic rate_write(input int v);
      @(negedge clk); rate_wr <= 1'b1; rate_val <= 8'(v);
      @(negedge clk); rate_wr <= 1'b0;
   endtask

   task automatic run_to_last();
      for (int i = 0; i < 300 && m_cnt != 1; i++) tick_n(1);
   endtask

   initial begin
      int base;
      repeat (4) @(negedge clk);
      rst_n <= 1'b1;
      @(negedge clk);
      tag = "R1";
      check(poll_req == 1'b0, "reset strobe", poll_req, 0);
      check(pkt_valid == 1'b0, "reset packet", pkt_valid, 0);

      // default interval of 20 ticks (R1, R2)
      tag = "R2"; rsp_n = 0; rsp_delay = 1;
      en_write(1'b1);
      tick_n(19);
      check(req_count == 0, "no poll before 20th tick", req_count, 0);
      tick_n(1); @(negedge clk);
      check(req_count == 1, "poll after 20th tick", req_count, 1);
      tag = "R3";
      tick_n(40); @(negedge clk);
      check(req_count == 3, "periodic polls", req_count, 3);
      tag = "R8";
      check(pkt_valid == 1'b0, "empty reply no packet", pkt_valid, 0);

      // reply with data, held until accepted (R7)
      tag = "R7"; rsp_n = 3; rsp_delay = 2; pkt_ready <= 1'b0;
      tick_n(20); repeat (6) @(negedge clk);
      check(pkt_valid == 1'b1, "packet pending", pkt_valid, 1);
      check(pkt_data[15:0] == 16'h4000, "header bytes", pkt_data[15:0], 16'h4000);
      repeat (5) @(negedge clk);
      pkt_ready <= 1'b1; @(negedge clk); @(negedge clk);
      check(pkt_valid == 1'b0, "packet taken", pkt_valid, 0);

      // expiries dropped while packet untaken (R9)
      tag = "R9"; pkt_ready <= 1'b0; rsp_n = 2;
      base = req_count;
      tick_n(60); @(negedge clk);
      check(req_count - base == 1, "polls while busy dropped", req_count - base, 1);
      pkt_ready <= 1'b1; repeat (2) @(negedge clk);

      // rewrite of same enable value (R4)
      tag = "R4"; rsp_n = 0;
      base = req_count;
      tick_n(10); en_write(1'b1); tick_n(10); @(negedge clk);
      check(req_count - base == 1, "same-value enable ignored", req_count - base, 1);

      // disable cancels (R5)
      tag = "R5";
      tick_n(7); en_write(1'b0);
      base = req_count;
      tick_n(30); @(negedge clk);
      check(req_count == base, "no polls while off", req_count - base, 0);

      // rate writes (R6)
      tag = "R6";
      rate_write(5); tick_n(10); @(negedge clk);
      check(req_count == base, "rate write while off", req_count - base, 0);
      en_write(1'b1); tick_n(5); @(negedge clk);
      check(req_count - base == 1, "new rate used on enable", req_count - base, 1);
      tick_n(2); rate_write(3); base = req_count;
      tick_n(2); @(negedge clk);
      check(req_count == base, "restart on rate change", req_count - base, 0);
      tick_n(1); @(negedge clk);
      check(req_count - base == 1, "poll after new rate", req_count - base, 1);

      // rate write colliding with expiring tick (R10)
      tag = "R10";
      run_to_last(); base = req_count;
      @(negedge clk); tick <= 1'b1; rate_wr <= 1'b1; rate_val <= 8'd4;
      @(negedge clk); tick <= 1'b0; rate_wr <= 1'b0;
      repeat (2) @(negedge clk);
      check(req_count == base, "rate write beats expiry", req_count - base, 0);
      tick_n(3); @(negedge clk);
      check(req_count == base, "full new interval pending", req_count - base, 0);
      tick_n(1); @(negedge clk);
      check(req_count - base == 1, "poll after new interval", req_count - base, 1);
      run_to_last(); base = req_count;
      @(negedge clk); tick <= 1'b1; en_wr <= 1'b1; en_val <= 1'b0;
      @(negedge clk); tick <= 1'b0; en_wr <= 1'b0;
      repeat (2) @(negedge clk);
      check(req_count == base, "disable beats expiry", req_count - base, 0);

      // fastest rate, full-size reply, strobe width (R11)
      tag = "R11"; rsp_n = MAXB; rsp_delay = 0;
      rate_write(1); en_write(1'b1);
      base = req_count;
      tick_n(6); repeat (4) @(negedge clk);
      check(req_count - base == 6, "poll every tick", req_count - base, 6);
      en_write(1'b0);
      repeat (6) @(negedge clk);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule